// File: doc/BRIEF.md
# Addressed Two-Wire Switch-Control Target

This block is a target on an I2C bus that holds one 8-bit control word. Each bit of the word turns one analog switch channel on (1) or off (0). A bus master writes the word to set the switches and can read it back. The block runs on a fast system clock and oversamples the bus. SCL and SDA first pass through a synchronizer and a glitch filter. Start, repeated-start and stop conditions are then decoded from the filtered lines.

The 7-bit target address is split in two parts. The five upper bits are a parameter, with default `10010`. The two lower bits come from a pair of strap inputs, so up to four units can share a bus. The block pulls SDA low through an open-drain enable output. It never drives SDA high.

Top module: `i2c_chan_switch`

## Requirements
- R1: While `rst_n` is low at a clock edge, the switch word is cleared to 0 and the SDA pull-down enable is released. Both hold from the first edge after reset until a write.
- R2: The block acknowledges an address byte whose upper 7 bits equal {ADDR_HI, `addr_sel[1:0]`}, with `addr_sel[0]` as address bit 0. Bit 0 of the address byte selects read (1) or write (0).
- R3: For an address that does not match, the block gives no acknowledge on any byte and leaves the switch word unchanged until the next start condition.
- R4: In a write, each data byte arrives MSB first and is acknowledged. `sw_o[n]` takes the byte's bit n during that byte's acknowledge slot, not earlier.
- R5: Several data bytes in one write are each acknowledged. Each one replaces the switch word in turn.
- R6: In a read, the block shifts out the current switch word MSB first. It releases SDA during the master's acknowledge slot.
- R7: After a master acknowledge, the block sends the word again. After a master no-acknowledge, it keeps SDA released until the next start or stop.
- R8: A pulse on SCL or SDA shorter than FILT_CYCLES system clocks (10 cycles, which is 50 ns at 200 MHz) has no effect on decoding.
- R9: A stop or repeated start in the middle of a byte ends the transfer without changing the switch word. After a repeated start, the block takes a new address byte.
- R10: The block never pulls SDA low while idle or while ignoring the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, as sensed |
| sda_i | input | 1 | Bus data line, as sensed |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| addr_sel | input | 2 | Strap inputs giving the two lowest address bits |
| sw_o | output | 8 | Switch enables, one per channel |

## Verification
Every bus event reaches the decoder 2 synchronizer cycles plus FILT_CYCLES filter cycles after the line changes. The switch word then takes one more register stage after the falling SCL edge that ends a data byte, so it is due about 13 system cycles after that edge. The SDA pull-down follows the same path and changes about 12 to 13 cycles after an SCL fall. The bench holds each SCL phase for 25 system cycles. It samples the acknowledge, read data and switch word in the middle of the next SCL high phase, and it samples at falling clock edges, well clear of these latencies.

// File: rtl/i2c_chan_switch_pkg.sv
// Package: shared constants and the protocol state type for the switch target.
// Assumes: one data byte per transfer unit (I2C byte framing).
package i2c_chan_switch_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,   // no transfer
        S_ADDR,   // shifting in address byte
        S_AACK,   // driving address acknowledge
        S_WDATA,  // shifting in write data
        S_WACK,   // driving data acknowledge
        S_RDATA,  // shifting out read data
        S_RACK,   // sampling master acknowledge
        S_SKIP    // not addressed; wait for start/stop
    } bus_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Module: synchronizes one bus line and rejects pulses shorter than
// FILT_CYCLES clocks. Assumes: bus lines idle high.
module i2c_line_filter #(
    parameter int FILT_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;

    // Two-stage synchronizer into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_i};
    end

    // Accept a new level only after it has held for FILT_CYCLES clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else if (sync_q[1] == line_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(FILT_CYCLES - 1)) begin
            cnt_q  <= '0;
            line_o <= sync_q[1];
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R8: the filtered level only moves toward the synchronized input
    a_r8_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(line_o) |-> line_o == $past(sync_q[1]));
endmodule

// File: rtl/i2c_target_fsm.sv
// Module: bus condition decode and byte-level protocol engine.
// Assumes filtered, synchronous SCL/SDA; issues a one-cycle write strobe
// when a data byte has been received and acknowledged.
module i2c_target_fsm
    import i2c_chan_switch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [6:0]        own_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);
    bus_state_t        state;
    logic              scl_d, sda_d;
    logic [2:0]        bit_cnt;
    logic              full;
    logic              rw;
    logic              nack;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              scl_rise, scl_fall, start_c, stop_c;

    // Previous filtered levels for edge and condition detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_rise = scl_f & ~scl_d;
        scl_fall = ~scl_f & scl_d;
        start_c  = scl_f & scl_d & sda_d & ~sda_f;
        stop_c   = scl_f & scl_d & ~sda_d & sda_f;
    end

    // Protocol sequencing: address, acknowledge, data in and data out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bit_cnt  <= '0;
            full     <= 1'b0;
            rw       <= 1'b0;
            nack     <= 1'b0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_c) begin
                state    <= S_ADDR;
                bit_cnt  <= '0;
                full     <= 1'b0;
                sda_pull <= 1'b0;
            end else if (stop_c) begin
                state    <= S_IDLE;
                full     <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 3'd1;
                            full    <= (bit_cnt == 3'd7);
                        end else if (scl_fall && full) begin
                            full    <= 1'b0;
                            bit_cnt <= '0;
                            if (state == S_ADDR) begin
                                if (rx_sh[7:1] == own_addr) begin
                                    state    <= S_AACK;
                                    sda_pull <= 1'b1;
                                    rw       <= rx_sh[0];
                                end else begin
                                    state <= S_SKIP;
                                end
                            end else begin
                                state    <= S_WACK;
                                sda_pull <= 1'b1;
                                wr_en    <= 1'b1;
                                wr_data  <= rx_sh;
                            end
                        end
                    end
                    S_AACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                state    <= S_RDATA;
                                tx_sh    <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                            end else begin
                                state    <= S_WDATA;
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    S_WACK: begin
                        if (scl_fall) begin
                            state    <= S_WDATA;
                            sda_pull <= 1'b0;
                        end
                    end
                    S_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 3'd1;
                            full    <= (bit_cnt == 3'd7);
                        end else if (scl_fall) begin
                            if (full) begin
                                full     <= 1'b0;
                                bit_cnt  <= '0;
                                sda_pull <= 1'b0;
                                state    <= S_RACK;
                            end else begin
                                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    S_RACK: begin
                        if (scl_rise) begin
                            nack <= sda_f;
                        end else if (scl_fall) begin
                            if (nack) begin
                                state <= S_SKIP;
                            end else begin
                                state    <= S_RDATA;
                                tx_sh    <= rd_data;
                                sda_pull <= ~rd_data[BYTE_W-1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: no pull-down while idle
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_IDLE |-> !sda_pull);
    // R3: no pull-down while ignoring the bus
    a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_SKIP |-> !sda_pull);
    // R4: a write strobe only accompanies the data acknowledge
    a_r4_write_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> state == S_WACK && sda_pull);
    // R6: the master acknowledge slot is never driven
    a_r6_rack_released: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_RACK |-> !sda_pull);
endmodule

// File: rtl/i2c_chan_switch.sv
// Module: top of the addressed switch-control target. Filters both bus
// lines, runs the protocol engine and holds the switch word.
// Assumes: addr_sel is a static strap and needs no synchronizer.
module i2c_chan_switch #(
    parameter logic [4:0] ADDR_HI     = 5'b10010,
    parameter int         FILT_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [1:0] addr_sel,
    output logic [7:0] sw_o
);
    import i2c_chan_switch_pkg::*;

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic               wr_en;
    logic [BYTE_W-1:0]  wr_data;
    logic [BYTE_W-1:0]  sw_q;

    assign raw_lines = {sda_i, scl_i};

    // One glitch filter per bus line
    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        i2c_line_filter #(.FILT_CYCLES(FILT_CYCLES)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    i2c_target_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[0]),
        .sda_f    (filt_lines[1]),
        .own_addr ({ADDR_HI, addr_sel}),
        .rd_data  (sw_q),
        .sda_pull (sda_pull_o),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    // Switch word register, loaded by acknowledged write bytes
    always_ff @(posedge clk) begin
        if (!rst_n)     sw_q <= '0;
        else if (wr_en) sw_q <= wr_data;
    end

    assign sw_o = sw_q;

    // R1: switches are off right after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sw_o == '0 && !sda_pull_o);
    // R9: the switch word changes only through a write strobe
    a_r9_change_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(sw_q) |-> $past(wr_en));
endmodule

// File: tb/i2c_chan_switch_tb_top.sv
module i2c_chan_switch_tb_top;
    localparam int Q = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b01;
    logic       sda_pull;
    logic [7:0] sw;
    logic       sda_bus;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_chan_switch dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .addr_sel   (addr_sel),
        .sw_o       (sw)
    );

    // {address byte, data byte, expected ack, expected switch word}
    localparam bit [24:0] VEC [0:6] = '{
        {8'h92, 8'h5A, 1'b1, 8'h5A},
        {8'h90, 8'hFF, 1'b0, 8'h5A},
        {8'h92, 8'h81, 1'b1, 8'h81},
        {8'h96, 8'h00, 1'b0, 8'h81},
        {8'hB2, 8'h00, 1'b0, 8'h81},
        {8'h92, 8'h00, 1'b1, 8'h00},
        {8'h92, 8'hFF, 1'b1, 8'hFF}
    };

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    // One bit with optional short SCL pulse (low phase) or SDA dip (high phase)
    task automatic bit_out(input logic b, input bit g_scl, input bit g_sda);
        sda_m = b;
        if (g_scl) begin
            wq(8); scl_m = 1'b1; wq(6); scl_m = 1'b0; wq(Q - 14);
        end else begin
            wq(Q);
        end
        scl_m = 1'b1;
        if (g_sda) begin
            wq(8); sda_m = 1'b0; wq(6); sda_m = b; wq(Q - 14);
        end else begin
            wq(Q);
        end
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic ack_slot(output logic ack);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(v[i], 1'b0, 1'b0);
        ack_slot(ack);
    endtask

    task automatic read_byte(input bit m_ack, output logic [7:0] v, output logic rel);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q);
            v[i] = sda_bus; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = ~m_ack; wq(Q);
        scl_m = 1'b1; wq(Q);
        rel = ~sda_pull; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic write1(input logic [7:0] a, input logic [7:0] d);
        logic k;
        bus_start;
        send_byte(a, k);
        send_byte(d, k);
        bus_stop;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic       ack;
        logic       rel;
        logic [7:0] rd;
        wq(5);
        rst_n = 1'b1;
        wq(20);
        chk("R1 reset switch word", sw, 8'h00);
        chk("R1 reset sda released", sda_pull, 1'b0);

        // Table of single-byte writes: R2 match, R3 mismatch, R4 data
        foreach (VEC[i]) begin
            bus_start;
            send_byte(VEC[i][24:17], ack);
            chk("R2/R3 address ack", ack, VEC[i][8]);
            send_byte(VEC[i][16:9], ack);
            chk("R3/R4 data ack", ack, VEC[i][8]);
            chk("R4 switch word", sw, VEC[i][7:0]);
            bus_stop;
            chk("R10 released after stop", sda_pull, 1'b0);
        end

        // R4: switch word must not change before the ack slot
        bus_start;
        send_byte(8'h92, ack);
        for (int i = 7; i >= 1; i--) bit_out(1'b0, 1'b0, 1'b0);
        chk("R4 no update before ack", sw, 8'hFF);
        bit_out(1'b0, 1'b0, 1'b0);
        ack_slot(ack);
        chk("R4 update at ack", sw, 8'h00);
        bus_stop;

        // R5: multi-byte write
        bus_start;
        send_byte(8'h92, ack);
        send_byte(8'h11, ack);
        chk("R5 first byte", sw, 8'h11);
        send_byte(8'h22, ack);
        chk("R5 second byte ack", ack, 1'b1);
        chk("R5 second byte", sw, 8'h22);
        bus_stop;

        // R6/R7: read back with master ack then nack
        write1(8'h92, 8'hC3);
        bus_start;
        send_byte(8'h93, ack);
        chk("R2 read address ack", ack, 1'b1);
        read_byte(1'b1, rd, rel);
        chk("R6 read data", rd, 8'hC3);
        chk("R6 ack slot released", rel, 1'b1);
        read_byte(1'b0, rd, rel);
        chk("R7 repeat read after ack", rd, 8'hC3);
        wq(Q);
        chk("R7 released after nack", sda_pull, 1'b0);
        bus_stop;

        // R8: SCL glitch in a low phase and SDA dip in a high phase
        bus_start;
        send_byte(8'h92, ack);
        bit_out(1'b0, 1'b0, 1'b0);
        bit_out(1'b1, 1'b1, 1'b0);
        bit_out(1'b1, 1'b0, 1'b1);
        bit_out(1'b0, 1'b1, 1'b0);
        bit_out(1'b1, 1'b0, 1'b1);
        bit_out(1'b0, 1'b0, 1'b0);
        bit_out(1'b1, 1'b0, 1'b1);
        bit_out(1'b1, 1'b0, 1'b0);
        ack_slot(ack);
        chk("R8 ack despite glitches", ack, 1'b1);
        chk("R8 data despite glitches", sw, 8'h6B);
        bus_stop;

        // R9: stop mid-byte
        bus_start;
        send_byte(8'h92, ack);
        for (int i = 0; i < 3; i++) bit_out(1'b1, 1'b0, 1'b0);
        bus_stop;
        chk("R9 stop mid byte keeps word", sw, 8'h6B);

        // R9: repeated start mid-byte, then a new address
        bus_start;
        send_byte(8'h92, ack);
        for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0, 1'b0);
        bus_start;
        chk("R9 repeated start keeps word", sw, 8'h6B);
        send_byte(8'h92, ack);
        chk("R9 new address after restart", ack, 1'b1);
        send_byte(8'h3C, ack);
        chk("R9 write after restart", sw, 8'h3C);
        bus_stop;

        // R2: strap change moves the address
        addr_sel = 2'b10;
        wq(4);
        bus_start;
        send_byte(8'h92, ack);
        chk("R2 old address now ignored", ack, 1'b0);
        bus_stop;
        bus_start;
        send_byte(8'h94, ack);
        chk("R2 new strap address ack", ack, 1'b1);
        send_byte(8'hA5, ack);
        chk("R2 new strap write", sw, 8'hA5);
        bus_stop;

        // R1: reset mid-run clears the switch word
        rst_n = 1'b0;
        wq(3);
        rst_n = 1'b1;
        wq(2);
        chk("R1 reset clears word", sw, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule